// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of one burst for a double-data-rate memory. A mode write, accepted only when the bank-select bits are all zero, sets the burst length (2, 4 or 8 beats), the burst ordering (sequential or interleaved) and a latency code. That code is only held and driven out. When the sequencer is idle, a start pulse with a starting column launches a burst. From the next cycle it emits one column address per clock, and it marks the final beat.

All addresses of a burst stay inside an aligned block whose size equals the burst length. The low address bits that select a position in the block either count up and wrap (sequential) or are the start position XOR the beat index (interleaved). The bits above the block never change during a burst. A mode write that carries a reserved length code is rejected: an error flag rises, and the previous settings stay in force.

Top module: `burst_col_seq`

## Requirements
- R1: Mode field bits [2:0] give the burst length: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8. A burst drives `beat_valid` for exactly that many consecutive cycles, with `beat_last` high only in the final one.
- R2: Mode bit [3] gives the order: 0 is sequential and 1 is interleaved.
- R3: In sequential order with length L and start position s = start_col mod L, beat k carries low position (s + k) mod L.
- R4: In interleaved order, beat k carries low position s XOR k.
- R5: The column bits at and above log2(L) equal those of `start_col` on every beat, so a wrap never carries into them.
- R6: A mode write with `mode_bank` not equal to 2'b00 is ignored: `mode_err`, `lat_code` and the burst settings keep their values.
- R7: A base mode write with a reserved length code (3'b000 or 3'b1xx) sets `mode_err` and leaves the length, order and latency settings unchanged. A later valid base write clears `mode_err`.
- R8: `lat_code` shows mode bits [6:4] of the latest accepted base mode write.
- R9: A start seen while idle puts beat 0 (`col_out` = `start_col`) on the outputs in the next cycle. A start seen while a burst is in progress is ignored, and this includes the cycle of the final beat.
- R10: After reset no beat is valid, `mode_err` is 0, `lat_code` is 0, and the settings are length 2 with sequential order.
- R11: The length and order are captured at start. A mode write during a burst does not change that burst and applies from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode write strobe |
| mode_bank | input | 2 | Register select; only 2'b00 addresses this block |
| mode_word | input | MODE_W | Mode field: [2:0] length, [3] order, [6:4] latency |
| start | input | 1 | Burst start request |
| start_col | input | COL_W | Starting column address |
| beat_valid | output | 1 | A column address is present this cycle |
| col_out | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| mode_err | output | 1 | Latest base mode write carried a reserved length |
| lat_code | output | 3 | Held latency code |

## Verification
A corrupted beat counter shows up as a wrong low column or a misplaced `beat_last` within one cycle of the faulty beat. A count that overruns shows up as `beat_valid` staying high past the expected length. A wrong captured length or order is visible on the second beat of the next burst. A mode register that accepts extended or reserved writes shows up at once on `mode_err` or `lat_code`, and in the length of the following burst. The bench therefore compares every beat of every burst, together with the idle cycle that follows it, against arithmetic expectations.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   localparam int MAX_LG = 3;
   localparam int LG_W   = 2;

   typedef enum logic {BT_SEQ = 1'b0, BT_XOR = 1'b1} btype_t;

   typedef struct packed {
      logic [LG_W-1:0] len_lg;
      btype_t          btype;
      logic [2:0]      lat;
   } bcfg_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
   import burst_seq_pkg::*;
#(
   parameter int MODE_W = 7,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] bank,
   input  logic [MODE_W-1:0] word,
   output bcfg_t             cfg,
   output logic              err
);
   generate
      if (MODE_W != 7) begin : g_bad_mode_w
         $error("burst_mode_reg: MODE_W must be 7");
      end
   endgenerate

   logic [2:0] len_code;
   logic       code_ok;
   logic       base_sel;
   bcfg_t      next_cfg;

   always_comb begin
      len_code        = word[2:0];
      code_ok         = (len_code != 3'd0) && !len_code[2];
      base_sel        = we && (bank == '0);
      next_cfg.len_lg = len_code[1:0];
      next_cfg.btype  = btype_t'(word[3]);
      next_cfg.lat    = word[6:4];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '{len_lg: LG_W'(1), btype: BT_SEQ, lat: 3'd0};
         err <= 1'b0;
      end else if (base_sel) begin
         if (code_ok) begin
            cfg <= next_cfg;
            err <= 1'b0;
         end else begin
            err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
   import burst_seq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic [LG_W-1:0]   cfg_lg,
   input  btype_t            cfg_type,
   output logic              busy,
   output logic              last,
   output logic [MAX_LG-1:0] idx,
   output logic [COL_W-1:0]  base_col,
   output logic [LG_W-1:0]   cur_lg,
   output btype_t            cur_type
);
   logic [MAX_LG-1:0] span;

   for (genvar i = 0; i < MAX_LG; i++) begin : g_span
      assign span[i] = (cur_lg > LG_W'(i));
   end

   assign last = busy && (idx == span);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         idx      <= '0;
         base_col <= '0;
         cur_lg   <= LG_W'(1);
         cur_type <= BT_SEQ;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            idx      <= '0;
            base_col <= start_col;
            cur_lg   <= cfg_lg;
            cur_type <= cfg_type;
         end
      end else if (last) begin
         busy <= 1'b0;
         idx  <= '0;
      end else begin
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
   import burst_seq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0]  base_col,
   input  logic [MAX_LG-1:0] idx,
   input  logic [LG_W-1:0]   len_lg,
   input  btype_t            btype,
   output logic [COL_W-1:0]  col
);
   logic [MAX_LG-1:0] off;
   logic [MAX_LG-1:0] seq_pos;
   logic [MAX_LG-1:0] xor_pos;
   logic [MAX_LG-1:0] pos;

   assign off     = base_col[MAX_LG-1:0];
   assign seq_pos = off + idx;
   assign xor_pos = off ^ idx;
   assign pos     = (btype == BT_XOR) ? xor_pos : seq_pos;

   for (genvar i = 0; i < MAX_LG; i++) begin : g_low
      assign col[i] = (len_lg > LG_W'(i)) ? pos[i] : base_col[i];
   end

   if (COL_W > MAX_LG) begin : g_high
      assign col[COL_W-1:MAX_LG] = base_col[COL_W-1:MAX_LG];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 7,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [BANK_W-1:0] mode_bank,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   output logic              beat_valid,
   output logic [COL_W-1:0]  col_out,
   output logic              beat_last,
   output logic              mode_err,
   output logic [2:0]        lat_code
);
   generate
      if (COL_W < MAX_LG) begin : g_bad_col_w
         $error("burst_col_seq: COL_W must cover the largest burst");
      end
      if (BANK_W < 1) begin : g_bad_bank_w
         $error("burst_col_seq: BANK_W must be at least 1");
      end
   endgenerate

   bcfg_t             cfg;
   logic [MAX_LG-1:0] idx;
   logic [COL_W-1:0]  base_col;
   logic [LG_W-1:0]   cur_lg;
   btype_t            cur_type;

   burst_mode_reg #(.MODE_W(MODE_W), .BANK_W(BANK_W)) u_mode (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mode_we),
      .bank (mode_bank),
      .word (mode_word),
      .cfg  (cfg),
      .err  (mode_err)
   );

   burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_col(start_col),
      .cfg_lg   (cfg.len_lg),
      .cfg_type (cfg.btype),
      .busy     (beat_valid),
      .last     (beat_last),
      .idx      (idx),
      .base_col (base_col),
      .cur_lg   (cur_lg),
      .cur_type (cur_type)
   );

   burst_addr_map #(.COL_W(COL_W)) u_map (
      .base_col(base_col),
      .idx     (idx),
      .len_lg  (cur_lg),
      .btype   (cur_type),
      .col     (col_out)
   );

   assign lat_code = cfg.lat;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W  = 10,
   parameter int MODE_W = 7,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_we,
   input logic [BANK_W-1:0] mode_bank,
   input logic [MODE_W-1:0] mode_word,
   input logic              start,
   input logic [COL_W-1:0]  start_col,
   input logic              beat_valid,
   input logic [COL_W-1:0]  col_out,
   input logic              beat_last,
   input logic              mode_err,
   input logic [2:0]        lat_code
);
   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid); // R1
   AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> !beat_valid); // R9
   AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last) |=> (beat_valid && $stable(col_out >> 3))); // R5
   AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !beat_valid) |=> (beat_valid && col_out == $past(start_col))); // R9
   AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && mode_bank != '0) |=> ($stable(mode_err) && $stable(lat_code))); // R6
   AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && mode_bank == '0 && (mode_word[2:0] == 3'd0 || mode_word[2]))
      |=> (mode_err && $stable(lat_code))); // R7
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .MODE_W(MODE_W), .BANK_W(BANK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_we   (mode_we),
   .mode_bank (mode_bank),
   .mode_word (mode_word),
   .start     (start),
   .start_col (start_col),
   .beat_valid(beat_valid),
   .col_out   (col_out),
   .beat_last (beat_last),
   .mode_err  (mode_err),
   .lat_code  (lat_code)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_we = 1'b0;
   logic [1:0]       mode_bank = 2'd0;
   logic [6:0]       mode_word = 7'd0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic             beat_valid, beat_last, mode_err;
   logic [COL_W-1:0] col_out;
   logic [2:0]       lat_code;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .MODE_W(7), .BANK_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_bank(mode_bank),
      .mode_word(mode_word), .start(start), .start_col(start_col),
      .beat_valid(beat_valid), .col_out(col_out), .beat_last(beat_last),
      .mode_err(mode_err), .lat_code(lat_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int s, input int len, input int typ, input int k);
      int pos;
      pos = typ ? ((s % len) ^ k) : (((s % len) + k) % len);
      return (s - (s % len)) + pos;
   endfunction

   task automatic load_mode(input int bank, input int word);
      mode_we   = 1'b1;
      mode_bank = 2'(bank);
      mode_word = 7'(word);
      @(negedge clk);
      mode_we   = 1'b0;
   endtask

   task automatic run_burst(input int s, input int len, input int typ, input string req);
      start     = 1'b1;
      start_col = COL_W'(s);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < len; k++) begin
         chk(beat_valid == 1'b1, {"R1 valid ", req}, beat_valid, 1);
         chk(col_out == COL_W'(exp_col(s, len, typ, k)), {"col ", req}, col_out, exp_col(s, len, typ, k));
         chk(beat_last == (k == len - 1), {"R1 last ", req}, beat_last, (k == len - 1));
         @(negedge clk);
      end
      chk(beat_valid == 1'b0, {"R1 end ", req}, beat_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(beat_valid == 1'b0, "R10 valid", beat_valid, 0);
      chk(beat_last == 1'b0, "R10 last", beat_last, 0);
      chk(mode_err == 1'b0, "R10 err", mode_err, 0);
      chk(lat_code == 3'd0, "R10 lat", lat_code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_burst(13, 2, 0, "R10 default length 2 sequential");

      // R1 R2 R3 R4 R5 R8: sweep every length, order and start position
      for (int lg = 1; lg <= 3; lg++) begin
         for (int t = 0; t <= 1; t++) begin
            int len;
            len = 1 << lg;
            load_mode(0, ((lg + t) << 4) | (t << 3) | lg);
            chk(lat_code == 3'(lg + t), "R8 lat after load", lat_code, lg + t);
            chk(mode_err == 1'b0, "R1 valid code no err", mode_err, 0);
            for (int s = 0; s < len; s++) begin
               int hi, sc;
               hi = (s * 37 + lg * 101 + t * 211) % 128;
               sc = hi * 8 + (((hi % 4) * len) % 8) + s;
               run_burst(sc, len, t, t ? "R2 R4 R5" : "R2 R3 R5");
            end
         end
      end
      // settings now: length 8, interleaved, lat 4

      // R6 extended writes ignored
      load_mode(1, (7 << 4) | 2);
      chk(lat_code == 3'd4, "R6 lat bank1", lat_code, 4);
      chk(mode_err == 1'b0, "R6 err bank1", mode_err, 0);
      load_mode(2, 0);
      chk(mode_err == 1'b0, "R6 err bank2 reserved", mode_err, 0);
      load_mode(3, (1 << 4) | 1);
      chk(lat_code == 3'd4, "R6 lat bank3", lat_code, 4);
      run_burst(677, 8, 1, "R6 settings kept");

      // R7 reserved codes
      for (int c = 0; c < 8; c++) begin
         if (c >= 1 && c <= 3) continue;
         load_mode(0, (6 << 4) | c);
         chk(mode_err == 1'b1, "R7 err set", mode_err, 1);
         chk(lat_code == 3'd4, "R7 lat kept", lat_code, 4);
      end
      run_burst(90, 8, 1, "R7 settings kept");
      load_mode(0, (3 << 4) | 2);
      chk(mode_err == 1'b0, "R7 err cleared", mode_err, 0);
      chk(lat_code == 3'd3, "R8 lat update", lat_code, 3);

      // R9 start while busy ignored, including the last beat
      start = 1'b1;
      start_col = COL_W'(257);
      @(negedge clk);
      chk(beat_valid && col_out == COL_W'(257), "R9 first beat", col_out, 257);
      start_col = COL_W'(1023);
      for (int k = 1; k < 4; k++) begin
         @(negedge clk);
         chk(col_out == COL_W'(exp_col(257, 4, 0, k)), "R9 busy start ignored", col_out, exp_col(257, 4, 0, k));
         chk(beat_last == (k == 3), "R9 last", beat_last, (k == 3));
      end
      @(negedge clk);
      chk(beat_valid == 1'b0, "R9 start at last beat ignored", beat_valid, 0);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk(beat_valid && col_out == COL_W'(exp_col(1023, 4, 0, k)), "R9 idle start", col_out, exp_col(1023, 4, 0, k));
         @(negedge clk);
      end
      chk(beat_valid == 1'b0, "R9 end", beat_valid, 0);

      // R11 mode write during a burst
      start = 1'b1;
      start_col = COL_W'(6);
      @(negedge clk);
      start = 1'b0;
      chk(col_out == COL_W'(6), "R11 beat0", col_out, 6);
      mode_we = 1'b1; mode_bank = 2'd0; mode_word = 7'((1 << 4) | (1 << 3) | 3);
      @(negedge clk);
      mode_we = 1'b0;
      for (int k = 1; k < 4; k++) begin
         chk(beat_valid && col_out == COL_W'(exp_col(6, 4, 0, k)), "R11 burst unchanged", col_out, exp_col(6, 4, 0, k));
         chk(beat_last == (k == 3), "R11 last", beat_last, (k == 3));
         @(negedge clk);
      end
      chk(beat_valid == 1'b0, "R11 end", beat_valid, 0);
      run_burst(5, 8, 1, "R11 new settings apply");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule